// File: doc/BRIEF.md
# Serial EEPROM Access and Burst Loader

This block lets a host read or write single bytes of an external byte-addressed EEPROM through a small set of registers. It can also run a burst that walks the EEPROM as a list of records and copies each record's data byte into an on-chip memory. The EEPROM is reached through an abstract handshake. The engine raises a request with an address, a write flag and write data. The device answers with a one-cycle done pulse that carries the read byte. No serial wire protocol is modelled.

A burst record is three bytes: a 16-bit destination offset, sent high byte first, then one data byte. An offset of 0xFFFF ends the burst. The destination memory address is 24 bits wide. Its upper 9 bits come from a host base register. Its lower 15 bits are the record offset with the offset's top bit dropped.

The engine keeps a next-address pointer equal to the last EEPROM address accessed plus one. A burst starts from that pointer, so the first burst after reset starts at EEPROM address 0.

Top module: `ee_burst_loader`

## Requirements
- R1: After reset, every host register reads 0. `ee_req` and `mem_we` are low. The next-address pointer is 0.
- R2: Writing select 0 (control) with bit 0 set starts a read of the EEPROM byte at the address register (select 1). Control bit 0 reads 1 until the byte arrives. The byte then appears in the data register (select 2, bits 7:0) and bit 0 reads 0.
- R3: Writing the control register with bit 1 set (and bit 0 clear) stores data register bits 7:0 at the addressed EEPROM location. Control bit 1 reads 1 until the access completes, then reads 0.
- R4: If one control write sets both bit 0 and bit 1, only the read is performed.
- R5: Control bit 2 reads 1 whenever any access or burst is in progress. While it is 1, writes to the control register and to the burst register are ignored.
- R6: After every EEPROM access the next-address pointer equals that access's address plus one, wrapping to 0 past the last EEPROM address.
- R7: Writing select 4 (burst) with bit 0 set starts a burst. Burst bit 0 reads 1 until the burst has ended, then reads 0.
- R8: A burst begins at EEPROM address 0 if there has been no access since reset. Otherwise it begins at the next-address pointer.
- R9: A burst reads three-byte records: offset high byte, offset low byte, data byte. Each record gives one memory write. An offset of 0xFFFF ends the burst and gives no write.
- R10: A burst memory write has `mem_addr` = {base register (select 3, bits 8:0), offset bits 14:0}. Offset bit 15 is ignored. `mem_data` is the record's data byte.
- R11: `ee_req` stays high from the start of an access or burst until the done of its last EEPROM access. `ee_we` is high only during a single-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_sel | input | 3 | Register select for the write |
| host_wr_data | input | 32 | Host write data |
| host_rd_sel | input | 3 | Register select for the read |
| host_rd_data | output | 32 | Read data for the selected register |
| ee_req | output | 1 | EEPROM access request |
| ee_we | output | 1 | Access is a write |
| ee_addr | output | ADDR_W | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_done | input | 1 | One-cycle completion pulse |
| ee_rdata | input | 8 | Read byte, valid with ee_done |
| mem_we | output | 1 | Burst memory write strobe |
| mem_addr | output | 24 | Burst memory write address |
| mem_data | output | 8 | Burst memory write data |

## Verification
The assertions check on every cycle the local rules of the sequencer:
- the address stays fixed while an access waits for done, whatever the host writes;
- the next-address pointer follows each completed access;
- a single access returns to idle on done;
- the write flag appears only for single writes;
- memory writes come only out of a record's data phase;
- a completed read reaches the data register.

Only the bench scenarios can show the end-to-end behaviours:
- the burst start point after reset, after single accesses and after address wrap;
- the decoding of whole record lists, including a dropped offset bit and the terminator;
- read-over-write priority;
- that requests made during a busy burst leave no trace.

// File: rtl/ee_burst_pkg.sv
package ee_burst_pkg;

    localparam int SEL_W   = 3;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ADDR  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DATA  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_BASE  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_BURST = 3'd4;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 16;
    localparam int LOW_W  = OFS_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SINGLE = 3'd1,
        ST_HI     = 3'd2,
        ST_LO     = 3'd3,
        ST_DAT    = 3'd4
    } seq_state_e;

endpackage

// File: rtl/ee_host_regs.sv
module ee_host_regs
    import ee_burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BASE_W = 9,
    parameter int HOST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [HOST_W-1:0] wr_data,
    input  logic              busy,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_byte,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BYTE_W-1:0] data_q,
    output logic [BASE_W-1:0] base_q,
    output logic              go_rd,
    output logic              go_wr,
    output logic              go_burst
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic [BASE_W-1:0] base;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        go_rd    = 1'b0;
        go_wr    = 1'b0;
        go_burst = 1'b0;
        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    go_rd = !busy && wr_data[0];
                    go_wr = !busy && !wr_data[0] && wr_data[1];
                end
                SEL_ADDR:  r_d.addr = wr_data[ADDR_W-1:0];
                SEL_DATA:  r_d.data = wr_data[BYTE_W-1:0];
                SEL_BASE:  r_d.base = wr_data[BASE_W-1:0];
                SEL_BURST: go_burst = !busy && wr_data[0];
                default: ;
            endcase
        end
        if (load_en) begin
            r_d.data = load_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_q = r_q.addr;
    assign data_q = r_q.data;
    assign base_q = r_q.base;

    // R2: a completed read lands in the data register
    p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (data_q == $past(load_byte)));

endmodule

// File: rtl/ee_access_seq.sv
module ee_access_seq
    import ee_burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BASE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go_rd,
    input  logic                    go_wr,
    input  logic                    go_burst,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic [BYTE_W-1:0]       wbyte_in,
    input  logic [BASE_W-1:0]       base_in,
    input  logic                    ee_done,
    input  logic [BYTE_W-1:0]       ee_rdata,
    output logic                    busy,
    output logic                    rd_active,
    output logic                    wr_active,
    output logic                    burst_active,
    output logic                    ee_req,
    output logic                    ee_we,
    output logic [ADDR_W-1:0]       ee_addr,
    output logic [BYTE_W-1:0]       ee_wdata,
    output logic                    load_en,
    output logic [BYTE_W-1:0]       load_byte,
    output logic                    mem_we,
    output logic [BASE_W+LOW_W-1:0] mem_addr,
    output logic [BYTE_W-1:0]       mem_data
);

    localparam int MEM_AW = BASE_W + LOW_W;
    localparam logic [OFS_W-1:0] END_MARK = '1;

    typedef struct packed {
        seq_state_e        st;
        logic              is_wr;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] nxt;
        logic [BYTE_W-1:0] wbyte;
        logic [BYTE_W-1:0] hi;
        logic [OFS_W-1:0]  ofs;
        logic              mwe;
        logic [MEM_AW-1:0] maddr;
        logic [BYTE_W-1:0] mdata;
    } seq_t;

    seq_t s_d, s_q;
    logic [ADDR_W-1:0] cur_inc;
    logic [OFS_W-1:0]  ofs_rx;

    assign cur_inc = s_q.cur + 1'b1;
    assign ofs_rx  = {s_q.hi, ee_rdata};

    always_comb begin
        s_d     = s_q;
        s_d.mwe = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (go_rd) begin
                    s_d.st    = ST_SINGLE;
                    s_d.is_wr = 1'b0;
                    s_d.cur   = addr_in;
                end else if (go_wr) begin
                    s_d.st    = ST_SINGLE;
                    s_d.is_wr = 1'b1;
                    s_d.cur   = addr_in;
                    s_d.wbyte = wbyte_in;
                end else if (go_burst) begin
                    s_d.st    = ST_HI;
                    s_d.is_wr = 1'b0;
                    s_d.cur   = s_q.nxt;
                end
            end
            ST_SINGLE: begin
                if (ee_done) begin
                    s_d.st  = ST_IDLE;
                    s_d.nxt = cur_inc;
                end
            end
            ST_HI: begin
                if (ee_done) begin
                    s_d.hi  = ee_rdata;
                    s_d.nxt = cur_inc;
                    s_d.cur = cur_inc;
                    s_d.st  = ST_LO;
                end
            end
            ST_LO: begin
                if (ee_done) begin
                    s_d.nxt = cur_inc;
                    s_d.cur = cur_inc;
                    if (ofs_rx == END_MARK) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.ofs = ofs_rx;
                        s_d.st  = ST_DAT;
                    end
                end
            end
            ST_DAT: begin
                if (ee_done) begin
                    s_d.mwe   = 1'b1;
                    s_d.maddr = {base_in, s_q.ofs[LOW_W-1:0]};
                    s_d.mdata = ee_rdata;
                    s_d.nxt   = cur_inc;
                    s_d.cur   = cur_inc;
                    s_d.st    = ST_HI;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy         = (s_q.st != ST_IDLE);
    assign rd_active    = (s_q.st == ST_SINGLE) && !s_q.is_wr;
    assign wr_active    = (s_q.st == ST_SINGLE) && s_q.is_wr;
    assign burst_active = (s_q.st == ST_HI) || (s_q.st == ST_LO) || (s_q.st == ST_DAT);
    assign ee_req       = busy;
    assign ee_we        = wr_active;
    assign ee_addr      = s_q.cur;
    assign ee_wdata     = s_q.wbyte;
    assign load_en      = rd_active && ee_done;
    assign load_byte    = ee_rdata;
    assign mem_we       = s_q.mwe;
    assign mem_addr     = s_q.maddr;
    assign mem_data     = s_q.mdata;

    // R5: host requests cannot move the address of a pending access
    p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ee_done) |=> $stable(ee_addr));

    // R6: the pointer follows every completed access
    p_next_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ee_done) |=> (s_q.nxt == $past(ee_addr) + 1'b1));

    // R2: a single access ends on its done pulse
    p_single_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SINGLE && ee_done) |=> !busy);

    // R11: the write flag only accompanies a pending request
    p_we_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ee_we |-> (ee_req && !burst_active));

    // R9: memory writes follow a data phase and return to the offset phase
    p_mem_from_dat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (s_q.st == ST_HI && $past(s_q.st) == ST_DAT));

endmodule

// File: rtl/ee_burst_loader.sv
module ee_burst_loader
    import ee_burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BASE_W = 9,
    parameter int HOST_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_wr_en,
    input  logic [SEL_W-1:0]        host_wr_sel,
    input  logic [HOST_W-1:0]       host_wr_data,
    input  logic [SEL_W-1:0]        host_rd_sel,
    output logic [HOST_W-1:0]       host_rd_data,
    output logic                    ee_req,
    output logic                    ee_we,
    output logic [ADDR_W-1:0]       ee_addr,
    output logic [BYTE_W-1:0]       ee_wdata,
    input  logic                    ee_done,
    input  logic [BYTE_W-1:0]       ee_rdata,
    output logic                    mem_we,
    output logic [BASE_W+LOW_W-1:0] mem_addr,
    output logic [BYTE_W-1:0]       mem_data
);

    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [BASE_W-1:0] base_q;
    logic go_rd, go_wr, go_burst;
    logic busy, rd_active, wr_active, burst_active;
    logic load_en;
    logic [BYTE_W-1:0] load_byte;

    ee_host_regs #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .HOST_W(HOST_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr_en),
        .wr_sel    (host_wr_sel),
        .wr_data   (host_wr_data),
        .busy      (busy),
        .load_en   (load_en),
        .load_byte (load_byte),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .base_q    (base_q),
        .go_rd     (go_rd),
        .go_wr     (go_wr),
        .go_burst  (go_burst)
    );

    ee_access_seq #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_rd        (go_rd),
        .go_wr        (go_wr),
        .go_burst     (go_burst),
        .addr_in      (addr_q),
        .wbyte_in     (data_q),
        .base_in      (base_q),
        .ee_done      (ee_done),
        .ee_rdata     (ee_rdata),
        .busy         (busy),
        .rd_active    (rd_active),
        .wr_active    (wr_active),
        .burst_active (burst_active),
        .ee_req       (ee_req),
        .ee_we        (ee_we),
        .ee_addr      (ee_addr),
        .ee_wdata     (ee_wdata),
        .load_en      (load_en),
        .load_byte    (load_byte),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_data     (mem_data)
    );

    always_comb begin
        host_rd_data = '0;
        case (host_rd_sel)
            SEL_CTRL:  host_rd_data[2:0]        = {busy, wr_active, rd_active};
            SEL_ADDR:  host_rd_data[ADDR_W-1:0] = addr_q;
            SEL_DATA:  host_rd_data[BYTE_W-1:0] = data_q;
            SEL_BASE:  host_rd_data[BASE_W-1:0] = base_q;
            SEL_BURST: host_rd_data[0]          = burst_active;
            default: ;
        endcase
    end

    // R10: memory address upper bits come from the base register
    p_mem_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $stable(base_q)) |-> (mem_addr[BASE_W+LOW_W-1:LOW_W] == base_q));

endmodule

// File: tb/ee_burst_loader_bench.sv
module ee_burst_loader_bench;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int LAT   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [2:0]  host_wr_sel = 3'd0;
    logic [31:0] host_wr_data = 32'd0;
    logic [2:0]  host_rd_sel = 3'd0;
    logic [31:0] host_rd_data;
    logic        ee_req, ee_we;
    logic [AW-1:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_done = 1'b0;
    logic [7:0]  ee_rdata = 8'd0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_data;

    always #5 clk = ~clk;

    ee_burst_loader #(.ADDR_W(AW)) u_ee_burst_loader (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
        .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_done(ee_done), .ee_rdata(ee_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] img [0:DEPTH-1];
    int ee_cnt = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // EEPROM device model, driven on the falling edge
    always @(negedge clk) begin
        if (ee_done) begin
            ee_done = 1'b0;
            ee_cnt  = 0;
        end else if (rst_n && ee_req) begin
            ee_cnt++;
            if (ee_cnt >= LAT) begin
                ee_done = 1'b1;
                if (ee_we) img[ee_addr] = ee_wdata;
                else       ee_rdata = img[ee_addr];
            end
        end
    end

    // Behavioural reference model
    int m_mode;   // 0 idle, 1 read, 2 write, 3 burst
    int m_step;   // burst byte index within a record
    int m_cur, m_next, m_addr, m_data, m_base, m_hi, m_ofs;
    longint mq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_step = 0; m_cur = 0; m_next = 0;
            m_addr = 0; m_data = 0; m_base = 0; m_hi = 0; m_ofs = 0;
        end else begin
            if (m_mode == 0 && host_wr_en) begin
                if (host_wr_sel == 3'd0 && host_wr_data[0]) begin
                    m_mode = 1; m_cur = m_addr;
                end else if (host_wr_sel == 3'd0 && host_wr_data[1]) begin
                    m_mode = 2; m_cur = m_addr;
                end else if (host_wr_sel == 3'd4 && host_wr_data[0]) begin
                    m_mode = 3; m_step = 0; m_cur = m_next;
                end
            end else if (m_mode != 0 && ee_done) begin
                m_next = (m_cur + 1) % DEPTH;
                if (m_mode == 1) begin
                    m_data = ee_rdata; m_mode = 0;
                end else if (m_mode == 2) begin
                    m_mode = 0;
                end else begin
                    if (m_step == 0) begin
                        m_hi = ee_rdata; m_step = 1;
                    end else if (m_step == 1) begin
                        m_ofs = m_hi * 256 + ee_rdata;
                        if (m_ofs == 16'hFFFF) m_mode = 0;
                        else m_step = 2;
                    end else begin
                        mq.push_back((longint'(m_base * 32768 + (m_ofs % 32768)) << 8) | ee_rdata);
                        m_step = 0;
                    end
                    m_cur = m_next;
                end
            end
            if (host_wr_en) begin
                if (host_wr_sel == 3'd1) m_addr = host_wr_data % DEPTH;
                if (host_wr_sel == 3'd2) m_data = host_wr_data % 256;
                if (host_wr_sel == 3'd3) m_base = host_wr_data % 512;
            end
        end
    end

    function automatic longint exp_rd(input logic [2:0] sel);
        case (sel)
            3'd0: return ((m_mode != 0) ? 4 : 0) + ((m_mode == 2) ? 2 : 0) + ((m_mode == 1) ? 1 : 0);
            3'd1: return m_addr;
            3'd2: return m_data;
            3'd3: return m_base;
            3'd4: return (m_mode == 3) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R11 ee_req", ee_req, (m_mode != 0));
            check("R11 ee_we", ee_we, (m_mode == 2));
            if (m_mode != 0) check("R8 ee_addr", ee_addr, m_cur);
            check("R5 host_rd_data", host_rd_data, exp_rd(host_rd_sel));
            if (mem_we) begin
                if (mq.size() == 0) check("R9 unexpected mem write", 1, 0);
                else check("R10 mem write", {mem_addr, mem_data}, mq.pop_front());
            end
        end
    end

    task automatic hwrite(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_sel = sel; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && ee_req; i++) @(negedge clk);
    endtask

    task automatic read_sel(input logic [2:0] sel, output logic [31:0] v);
        host_rd_sel = sel;
        #1;
        v = host_rd_data;
    endtask

    task automatic finish_run();
        check("R9 leftover mem writes", mq.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    logic [31:0] v;
    int wcount;
    always @(negedge clk) if (mem_we) wcount++;

    initial begin
        for (int i = 0; i < DEPTH; i++) img[i] = 8'((i * 7 + 3) % 256);
        // records at 0: {0x0012, A5}, {0x8034, 5C}, end
        img[0] = 8'h00; img[1] = 8'h12; img[2] = 8'hA5;
        img[3] = 8'h80; img[4] = 8'h34; img[5] = 8'h5C;
        img[6] = 8'hFF; img[7] = 8'hFF;
        // records at 0x102: {0x0001, 11}, end
        img[258] = 8'h00; img[259] = 8'h01; img[260] = 8'h11;
        img[261] = 8'hFF; img[262] = 8'hFF;
        wcount = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 5; s++) begin
            read_sel(3'(s), v);
            check("R1 reset register", v, 0);
        end
        check("R1 ee_req low", ee_req, 0);
        check("R1 mem_we low", mem_we, 0);

        // R8/R9/R10 first burst after reset from address 0
        hwrite(3'd3, 32'h1AB);
        mq.delete();
        hwrite(3'd4, 32'h1);
        check("R8 first burst at address 0", ee_addr, 0);
        read_sel(3'd4, v);
        check("R7 burst bit set", v, 1);
        // R5 request during burst ignored
        hwrite(3'd0, 32'h1);
        read_sel(3'd0, v);
        check("R5 read bit not taken while busy", v, 4);
        wait_idle();
        @(negedge clk);
        check("R9 two records written", wcount, 2);
        read_sel(3'd4, v);
        check("R7 burst bit cleared", v, 0);
        read_sel(3'd2, v);
        check("R5 data untouched by ignored read", v, 0);

        // R2 single read
        hwrite(3'd1, 32'd5);
        hwrite(3'd0, 32'h1);
        read_sel(3'd0, v);
        check("R2 read bit set while pending", v, 5);
        wait_idle();
        read_sel(3'd2, v);
        check("R2 data after read", v, img[5]);
        read_sel(3'd0, v);
        check("R2 read bit cleared", v, 0);

        // R3 single write
        hwrite(3'd1, 32'h100);
        hwrite(3'd2, 32'hC3);
        hwrite(3'd0, 32'h2);
        check("R11 ee_we during write", ee_we, 1);
        read_sel(3'd0, v);
        check("R3 write bit set while pending", v, 6);
        wait_idle();
        check("R3 byte stored", img[256], 8'hC3);
        read_sel(3'd0, v);
        check("R3 write bit cleared", v, 0);

        // R4 both bits: read only
        hwrite(3'd1, 32'h101);
        hwrite(3'd0, 32'h3);
        check("R4 no write flag", ee_we, 0);
        wait_idle();
        check("R4 location unchanged", img[257], 8'((257 * 7 + 3) % 256));
        read_sel(3'd2, v);
        check("R4 read data", v, img[257]);

        // R8 burst resumes after last access (0x101 -> 0x102)
        wcount = 0;
        hwrite(3'd3, 32'h0F0);
        hwrite(3'd4, 32'h1);
        check("R8 burst resumes at next address", ee_addr, 10'h102);
        wait_idle();
        @(negedge clk);
        check("R9 one record written", wcount, 1);

        // R6 wrap: read last address, burst starts at 0
        hwrite(3'd1, 32'h3FF);
        hwrite(3'd0, 32'h1);
        wait_idle();
        hwrite(3'd4, 32'h1);
        check("R6 pointer wraps to 0", ee_addr, 0);
        wait_idle();
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule